// File: doc/BRIEF.md
# Paired Output Compare Toggle Unit

This block drives two output pins from one up-counting timer and two compare values. The timer advances by one on each cycle where the count enable is high. When the timer value equals a compare value on such a cycle, that is a match. A match makes the pins it is routed to change level on the next clock edge. A two-bit mode input selects the routing. In independent routing, each pin answers only to its own compare value. In combined routing, pin 0 answers to compare 0, and pin 1 answers to either compare. Two compare values therefore place the rising and falling edges of one pulse on pin 1.

An optional clear input makes a compare-0 match return the timer to zero instead of letting it run on. Compare 0 then sets the period, and compare 1 sets the duty point of a PWM signal on pin 1. Each pin has its own toggle enable and its own synchronous preset. The compare values and all controls are plain input ports.

Top module: `pair_cmp_toggle`

## Requirements
- R1: The timer resets to 0. It increases by 1 on each clock edge where `cnt_en` is high and wraps from 0xFFFF to 0x0000. It holds its value when `cnt_en` is low.
- R2: With `mode` = 2'b00, `out0` inverts after each match of the timer with `cmp0`, and `out1` inverts after each match with `cmp1`.
- R3: With `mode` = 2'b01, `out0` inverts only after a match with `cmp0`, and `out1` inverts after a match with `cmp0` or with `cmp1`.
- R4: When the timer matches `cmp0` and `cmp1` on the same cycle in `mode` 2'b01, `out1` inverts once, the same result as `mode` 2'b00.
- R5: With `clr_on_match` high, a `cmp0` match loads the timer with 0 on that edge instead of incrementing it. The outputs still respond to that match on the same edge.
- R6: A low `tog_en0` or `tog_en1` stops its pin from inverting, and the pin holds its level.
- R7: A high `ld0` or `ld1` sets its pin to `ld_val0` or `ld_val1` on the next edge. The load takes priority over any toggle on that edge.
- R8: `mode` values 2'b10 and 2'b11 behave exactly as 2'b00.
- R9: After reset, `out0` and `out1` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Timer count enable; matches count only when high |
| clr_on_match | input | 1 | Clear the timer on a compare-0 match |
| mode | input | 2 | Match routing: 00 independent, 01 combined, others as 00 |
| cmp0 | input | 16 | Compare value 0 |
| cmp1 | input | 16 | Compare value 1 |
| tog_en0 | input | 1 | Toggle enable for out0 |
| tog_en1 | input | 1 | Toggle enable for out1 |
| ld0 | input | 1 | Preset strobe for out0 |
| ld1 | input | 1 | Preset strobe for out1 |
| ld_val0 | input | 1 | Preset level for out0 |
| ld_val1 | input | 1 | Preset level for out1 |
| count | output | 16 | Current timer value |
| out0 | output | 1 | Compare output pin 0 |
| out1 | output | 1 | Compare output pin 1 |

## Verification
A pin level is kept only as parity: every toggle flips it, so one lost or extra toggle leaves the pin wrong until the next load or reset. A count of final pin levels after a known run of matches therefore catches routing faults, double toggles on equal compare values and gating faults. The timer value is visible directly. A wrong clear or wrap shows on `count` on the edge after the match. It also moves every later match, so both pins go out of phase within one period.

// File: rtl/pair_cmp_toggle.sv
module pair_cmp_toggle #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             clr_on_match,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] cmp0,
  input  logic [WIDTH-1:0] cmp1,
  input  logic             tog_en0,
  input  logic             tog_en1,
  input  logic             ld0,
  input  logic             ld1,
  input  logic             ld_val0,
  input  logic             ld_val1,
  output logic [WIDTH-1:0] count,
  output logic             out0,
  output logic             out1
);

  localparam logic [1:0] MODE_COMBINED = 2'b01;

  logic hit0, hit1, flip0, flip1;

  assign hit0  = cnt_en && (count == cmp0);
  assign hit1  = cnt_en && (count == cmp1);
  assign flip0 = tog_en0 && hit0;
  assign flip1 = tog_en1 && ((mode == MODE_COMBINED) ? (hit0 || hit1) : hit1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (cnt_en)
      count <= (clr_on_match && hit0) ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out0 <= 1'b0;
      out1 <= 1'b0;
    end else begin
      if (ld0)        out0 <= ld_val0;
      else if (flip0) out0 <= ~out0;
      if (ld1)        out1 <= ld_val1;
      else if (flip1) out1 <= ~out1;
    end
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !(clr_on_match && count == cmp0)) |=> count == $past(count) + 1'b1);

  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && clr_on_match && count == cmp0) |=> count == '0);

  p_out0_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld0 && !(tog_en0 && cnt_en && count == cmp0)) |=> $stable(out0));

  p_single_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld1 && tog_en1 && cnt_en && count == cmp0 && count == cmp1) |=> out1 != $past(out1));

  p_preset0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld0 |=> out0 == $past(ld_val0));

  p_preset1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld1 |=> out1 == $past(ld_val1));

endmodule

// File: tb/pair_cmp_toggle_test.sv
module pair_cmp_toggle_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, clr_on_match = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [15:0] cmp0 = '0, cmp1 = '0;
  logic tog_en0 = 1'b1, tog_en1 = 1'b1;
  logic ld0 = 1'b0, ld1 = 1'b0, ld_val0 = 1'b0, ld_val1 = 1'b0;
  logic [15:0] count;
  logic out0, out1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pair_cmp_toggle uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr_on_match(clr_on_match),
    .mode(mode), .cmp0(cmp0), .cmp1(cmp1), .tog_en0(tog_en0), .tog_en1(tog_en1),
    .ld0(ld0), .ld1(ld1), .ld_val0(ld_val0), .ld_val1(ld_val1),
    .count(count), .out0(out0), .out1(out1));

  typedef struct packed {
    logic [1:0]  md;
    logic        clr;
    logic        e0;
    logic        e1;
    logic [15:0] c0;
    logic [15:0] c1;
    logic [15:0] n;
    logic [15:0] xc;
    logic        xo0;
    logic        xo1;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [0:NV-1] = '{
    '{2'b00, 1'b0, 1'b1, 1'b1, 16'd3, 16'd5, 16'd4, 16'd4, 1'b1, 1'b0},
    '{2'b00, 1'b0, 1'b1, 1'b1, 16'd3, 16'd5, 16'd6, 16'd6, 1'b1, 1'b1},
    '{2'b01, 1'b0, 1'b1, 1'b1, 16'd3, 16'd5, 16'd4, 16'd4, 1'b1, 1'b1},
    '{2'b01, 1'b0, 1'b1, 1'b1, 16'd3, 16'd5, 16'd6, 16'd6, 1'b1, 1'b0},
    '{2'b01, 1'b0, 1'b1, 1'b1, 16'd5, 16'd5, 16'd6, 16'd6, 1'b1, 1'b1},
    '{2'b10, 1'b0, 1'b1, 1'b1, 16'd3, 16'd5, 16'd4, 16'd4, 1'b1, 1'b0},
    '{2'b11, 1'b0, 1'b1, 1'b1, 16'd3, 16'd5, 16'd6, 16'd6, 1'b1, 1'b1},
    '{2'b00, 1'b1, 1'b1, 1'b1, 16'd3, 16'd9, 16'd4, 16'd0, 1'b1, 1'b0},
    '{2'b00, 1'b1, 1'b1, 1'b1, 16'd3, 16'd9, 16'd9, 16'd1, 1'b0, 1'b0},
    '{2'b01, 1'b1, 1'b1, 1'b1, 16'd3, 16'd1, 16'd9, 16'd1, 1'b0, 1'b0},
    '{2'b01, 1'b1, 1'b1, 1'b1, 16'd3, 16'd1, 16'd6, 16'd2, 1'b1, 1'b1},
    '{2'b00, 1'b0, 1'b0, 1'b1, 16'd3, 16'd1, 16'd4, 16'd4, 1'b0, 1'b1},
    '{2'b01, 1'b0, 1'b1, 1'b0, 16'd3, 16'd1, 16'd4, 16'd4, 1'b1, 1'b0}
  };
  // Tags per row: 0-1 R2, 2-3 R3, 4 R4, 5-6 R8, 7-10 R5, 11-12 R6

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    cnt_en = 1'b0; ld0 = 1'b0; ld1 = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    chk("R9 count", count, 16'd0);
    chk("R9 out0", {15'd0, out0}, 16'd0);
    chk("R9 out1", {15'd0, out1}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      mode = VEC[i].md; clr_on_match = VEC[i].clr;
      tog_en0 = VEC[i].e0; tog_en1 = VEC[i].e1;
      cmp0 = VEC[i].c0; cmp1 = VEC[i].c1;
      cnt_en = 1'b1;
      repeat (int'(VEC[i].n)) @(posedge clk);
      @(negedge clk);
      cnt_en = 1'b0;
      chk($sformatf("row %0d count (R1/R5)", i), count, VEC[i].xc);
      chk($sformatf("row %0d out0 (R2/R3/R6/R8)", i), {15'd0, out0}, {15'd0, VEC[i].xo0});
      chk($sformatf("row %0d out1 (R2/R3/R4/R8)", i), {15'd0, out1}, {15'd0, VEC[i].xo1});
    end

    // R1: hold with cnt_en low
    do_reset();
    mode = 2'b00; clr_on_match = 1'b0; tog_en0 = 1'b1; tog_en1 = 1'b1;
    cmp0 = 16'd2; cmp1 = 16'd2;
    cnt_en = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 hold count", count, 16'd2);
    chk("R1 hold out0", {15'd0, out0}, 16'd0);

    // R7: preset and priority over a toggle
    do_reset();
    cmp0 = 16'd0; cmp1 = 16'd7; mode = 2'b00;
    ld1 = 1'b1; ld_val1 = 1'b1;
    @(negedge clk);
    ld1 = 1'b0;
    chk("R7 preset out1", {15'd0, out1}, 16'd1);
    cnt_en = 1'b1; ld0 = 1'b1; ld_val0 = 1'b0;
    @(negedge clk);
    cnt_en = 1'b0; ld0 = 1'b0;
    chk("R7 load beats toggle out0", {15'd0, out0}, 16'd0);
    chk("R7 counter moved", count, 16'd1);

    // R1: wrap from 0xFFFF
    do_reset();
    mode = 2'b00; clr_on_match = 1'b0; tog_en0 = 1'b1; tog_en1 = 1'b1;
    cmp0 = 16'hFFFF; cmp1 = 16'h0000;
    cnt_en = 1'b1;
    repeat (65537) @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0;
    chk("R1 wrap count", count, 16'd1);
    chk("R1 wrap out0", {15'd0, out0}, 16'd1);
    chk("R1 wrap out1", {15'd0, out1}, 16'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule